// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Decoder

This block is the serial front end of a digital potentiometer controller. It watches a two-wire bus (a clock line and an open-drain data line) and oversamples both lines on the system clock. It finds bus START and STOP conditions and accepts an address byte only when that byte matches a fixed device identity and three strap pins. It then takes an instruction byte and turns each valid command into strobes and fields for a neighbouring register bank. That bank holds the live wiper setting and four stored settings.

There are three command shapes. Register-to-register transfers are complete after the instruction byte. Reads and writes carry one further data byte: on a read the block serialises a byte supplied by the register bank, and on a write it takes in a byte from the bus master. The step command switches the block into a mode where the master's clock pulses are not data at all. Each full clock pulse becomes one step request, and its direction is the level the data line held while the clock was high. This mode lasts until STOP. The block only pulls the data line low, through `sda_drive_low`, and the surrounding pad logic combines that with the bus.

Top module: `dpot_cmd_slave`

## Requirements
- R1: A START (data falling while clock is high) restarts address reception from any state, including partway through a byte. A STOP (data rising while clock is high) returns the block to idle. After either condition the block stops pulling the data line low.
- R2: The address byte is received MSB first and acknowledged (data held low through the ninth clock) only when bits 7..4 equal 0101, bits 3..1 equal `strap_addr`, and bit 0 is 0. After a mismatch nothing else is acknowledged until the next START.
- R3: The instruction byte holds the opcode in bits 7..4, the register select in bits 3..2 and the pot select in bits 1..0. It is acknowledged only when the pot select is 00 and the opcode is one of 1001 (read wiper), 1010 (write wiper), 1011 (read stored), 1100 (write stored), 1101 (stored to wiper), 1110 (wiper to stored) or 0010 (step). Any other instruction gets no acknowledge, and none of the bytes that follow it is acknowledged or raises a strobe.
- R4: After an accepted write opcode (1010 or 1100), the next byte is received MSB first and acknowledged. It raises `cmd_valid` for one cycle with `cmd_op`, `cmd_reg` and `cmd_data` holding the opcode, register select and byte.
- R5: An accepted transfer opcode (1101 or 1110) raises `cmd_valid` once, at the end of the instruction acknowledge, with no data byte.
- R6: After an accepted read opcode (1001 or 1011), the block drives `rd_data` out MSB first. The master's acknowledge makes it send `rd_data` again, freshly sampled. The master's NACK ends the transfer, and the block drives nothing until the next START.
- R7: After an accepted step opcode (0010), every complete clock pulse gives one `step_valid` pulse. `step_up` is 1 when data was high during that pulse and 0 when it was low. A STOP ends the mode without producing a step, and clock pulses outside the mode produce none.
- R8: `cmd_valid` and `step_valid` are single-cycle pulses and are never high together.
- R9: While reset is held, the block drives no strobes and does not pull the data line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the pad, asynchronous |
| strap_addr | input | 3 | Pin-strapped address bits |
| rd_data | input | 8 | Byte from the register bank for the selected read |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| cmd_valid | output | 1 | One-cycle strobe for a write or transfer command |
| cmd_op | output | 4 | Opcode of the current accepted instruction |
| cmd_reg | output | 2 | Register select of the current accepted instruction |
| cmd_pot | output | 2 | Pot select of the current accepted instruction (always 00) |
| cmd_data | output | 8 | Data byte for write commands |
| step_valid | output | 1 | One-cycle step request |
| step_up | output | 1 | Direction of the latest step, 1 for up |

## Verification
The bench goes after the address check bit by bit, with wrong identity, wrong strap and a set final bit. A decoder that compared too few bits would acknowledge a stranger's address. It sends random instruction bytes, where a decoder that ignored the pot select or accepted unlisted opcodes would acknowledge them and strobe a register change. On reads it changes the bank byte between repeats and then sends a NACK, which catches a block that keeps a stale byte or keeps driving after the NACK. In step mode it checks the exact up/down sequence and closes with a STOP, whose final clock rise must not count as a step. It also interrupts an address byte with a repeated START, which a decoder with a stuck bit count would mis-frame.

// File: rtl/dpot_cmd_pkg.sv
// Shared constants and types for the potentiometer command decoder.
// Assumes byte-wide bus transfers and a fixed four-bit device identity.
package dpot_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;
    localparam int SEL_W  = 2;
    localparam int POT_W  = 2;
    localparam int ADDR_W = 3;
    localparam int ID_W   = BYTE_W - ADDR_W - 1;

    localparam logic [ID_W-1:0] DEV_ID = 4'b0101;

    // Opcode values accepted in the instruction byte
    typedef enum logic [OP_W-1:0] {
        OP_STEP       = 4'b0010,
        OP_RD_WIPER   = 4'b1001,
        OP_WR_WIPER   = 4'b1010,
        OP_RD_STORE   = 4'b1011,
        OP_WR_STORE   = 4'b1100,
        OP_LOAD_WIPER = 4'b1101,
        OP_SAVE_WIPER = 4'b1110
    } op_e;

    // Field view of the address byte, MSB first on the wire
    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] pins;
        logic              dir;
    } addr_byte_t;

    // Field view of the instruction byte, MSB first on the wire
    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] sel;
        logic [POT_W-1:0] pot;
    } instr_byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_RD_RELOAD,
        ST_STEP,
        ST_PARK
    } frame_state_e;

    // True for the seven opcodes the decoder recognises
    function automatic logic op_known(input logic [OP_W-1:0] op);
        case (op)
            OP_STEP, OP_RD_WIPER, OP_WR_WIPER, OP_RD_STORE,
            OP_WR_STORE, OP_LOAD_WIPER, OP_SAVE_WIPER: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dpot_bus_sync.sv
// Multi-stage synchroniser for asynchronous bus lines.
// Assumes STAGES >= 2; lines reset to the idle-high bus level.
module dpot_bus_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] pipe;

            // Shift the raw level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= '1;
                end else begin
                    pipe <= {pipe[STAGES-2:0], raw[g]};
                end
            end

            assign synced[g] = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dpot_cond_detect.sv
// Edge and bus-condition detector on synchronised clock and data lines.
// Assumes both inputs share the same synchroniser latency.
module dpot_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p,
    output logic sda_lvl
);

    logic scl_q;
    logic sda_q;

    // Hold the previous sample of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
    assign sda_lvl  = sda_s;

endmodule

// File: rtl/dpot_frame_fsm.sv
// Byte framing, address match, instruction decode, read serialiser and
// step mode. Assumes single-cycle edge pulses from the condition detector
// and that the data line only changes while the clock line is low.
module dpot_frame_fsm
    import dpot_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_lvl,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_drive_low,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [SEL_W-1:0]  cmd_reg,
    output logic [POT_W-1:0]  cmd_pot,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              step_valid,
    output logic              step_up
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    frame_state_e      state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              drive_q;
    logic [OP_W-1:0]   op_q;
    logic [SEL_W-1:0]  sel_q;
    logic [POT_W-1:0]  pot_q;
    logic [BYTE_W-1:0] data_q;
    logic              cmd_pulse;
    logic              step_pulse;
    logic              step_dir;
    logic              dir_latch;
    logic              step_armed;

    addr_byte_t  addr_view;
    instr_byte_t instr_view;
    logic        addr_hit;
    logic        instr_ok;

    // Field views of the received byte and the accept decisions
    always_comb begin
        addr_view  = addr_byte_t'(shreg);
        instr_view = instr_byte_t'(shreg);
        addr_hit   = (addr_view.id == DEV_ID) && (addr_view.pins == strap_addr)
                     && !addr_view.dir;
        instr_ok   = op_known(instr_view.op) && (instr_view.pot == '0);
    end

    // Protocol sequencer: one transition per bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            drive_q    <= 1'b0;
            op_q       <= '0;
            sel_q      <= '0;
            pot_q      <= '0;
            data_q     <= '0;
            cmd_pulse  <= 1'b0;
            step_pulse <= 1'b0;
            step_dir   <= 1'b0;
            dir_latch  <= 1'b0;
            step_armed <= 1'b0;
        end else begin
            cmd_pulse  <= 1'b0;
            step_pulse <= 1'b0;
            if (stop_p) begin
                state   <= ST_IDLE;
                drive_q <= 1'b0;
            end else if (start_p) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                drive_q <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INSTR, ST_WDATA: begin
                        if (scl_rise && bit_cnt != FULL_CNT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL_CNT) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    drive_q <= 1'b1;
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_PARK;
                                end
                            end else if (state == ST_INSTR) begin
                                if (instr_ok) begin
                                    drive_q <= 1'b1;
                                    op_q    <= instr_view.op;
                                    sel_q   <= instr_view.sel;
                                    pot_q   <= instr_view.pot;
                                    state   <= ST_INSTR_ACK;
                                end else begin
                                    state <= ST_PARK;
                                end
                            end else begin
                                drive_q   <= 1'b1;
                                data_q    <= shreg;
                                cmd_pulse <= 1'b1;
                                state     <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            state   <= ST_INSTR;
                        end
                    end
                    ST_INSTR_ACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            case (op_q)
                                OP_WR_WIPER, OP_WR_STORE: state <= ST_WDATA;
                                OP_RD_WIPER, OP_RD_STORE: begin
                                    txreg   <= rd_data;
                                    drive_q <= ~rd_data[BYTE_W-1];
                                    state   <= ST_RDATA;
                                end
                                OP_STEP: begin
                                    step_armed <= 1'b0;
                                    state      <= ST_STEP;
                                end
                                default: begin
                                    cmd_pulse <= 1'b1;
                                    state     <= ST_PARK;
                                end
                            endcase
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            drive_q <= 1'b0;
                            state   <= ST_PARK;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && bit_cnt != FULL_CNT) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL_CNT) begin
                            bit_cnt <= '0;
                            drive_q <= 1'b0;
                            state   <= ST_RD_ACK;
                        end else if (scl_fall && bit_cnt != '0) begin
                            txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                            drive_q <= ~txreg[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            state <= sda_lvl ? ST_PARK : ST_RD_RELOAD;
                        end
                    end
                    ST_RD_RELOAD: begin
                        if (scl_fall) begin
                            txreg   <= rd_data;
                            drive_q <= ~rd_data[BYTE_W-1];
                            state   <= ST_RDATA;
                        end
                    end
                    ST_STEP: begin
                        if (scl_rise) begin
                            dir_latch  <= sda_lvl;
                            step_armed <= 1'b1;
                        end else if (scl_fall && step_armed) begin
                            step_pulse <= 1'b1;
                            step_dir   <= dir_latch;
                            step_armed <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_drive_low = drive_q;
    assign cmd_valid     = cmd_pulse;
    assign cmd_op        = op_q;
    assign cmd_reg       = sel_q;
    assign cmd_pot       = pot_q;
    assign cmd_data      = data_q;
    assign step_valid    = step_pulse;
    assign step_up       = step_dir;

endmodule

// File: rtl/dpot_cmd_slave.sv
// Top of the potentiometer command decoder: synchroniser, bus condition
// detector and framing sequencer. Assumes the system clock is fast enough
// that each bus clock phase spans several system cycles.
module dpot_cmd_slave
    import dpot_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_drive_low,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [SEL_W-1:0]  cmd_reg,
    output logic [POT_W-1:0]  cmd_pot,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              step_valid,
    output logic              step_up
);

    logic [1:0] lines_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_p;
    logic       stop_p;
    logic       sda_lvl;

    dpot_bus_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({sda_in, scl_in}),
        .synced (lines_s)
    );

    dpot_cond_detect u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[0]),
        .sda_s    (lines_s[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .sda_lvl  (sda_lvl)
    );

    dpot_frame_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_p       (start_p),
        .stop_p        (stop_p),
        .sda_lvl       (sda_lvl),
        .strap_addr    (strap_addr),
        .rd_data       (rd_data),
        .sda_drive_low (sda_drive_low),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_reg       (cmd_reg),
        .cmd_pot       (cmd_pot),
        .cmd_data      (cmd_data),
        .step_valid    (step_valid),
        .step_up       (step_up)
    );

endmodule

// File: rtl/dpot_cmd_checker.sv
// Protocol properties for the command decoder, bound onto its top.
// Assumes the bound scope exposes the detected START and STOP pulses.
module dpot_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       step_valid,
    input logic       sda_drive_low,
    input logic       start_p,
    input logic       stop_p,
    input logic [1:0] cmd_pot
);

    // R9: a cycle under reset leaves outputs quiet
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !step_valid && !sda_drive_low));

    // R8: command strobe lasts one cycle
    a_r8_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8: step strobe lasts one cycle
    a_r8_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !step_valid);

    // R8: the two strobes never coincide
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && step_valid));

    // R3: commands only ever target pot select 00
    a_r3_pot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_pot == 2'b00));

    // R1: STOP releases the data line
    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_drive_low);

    // R1: START releases the data line
    a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_drive_low);

endmodule

bind dpot_cmd_slave dpot_cmd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .step_valid    (step_valid),
    .sda_drive_low (sda_drive_low),
    .start_p       (start_p),
    .stop_p        (stop_p),
    .cmd_pot       (cmd_pot)
);

// File: tb/dpot_cmd_slave_tb.sv
// Self-checking bench: a bus master model drives the decoder, bench
// functions compute expected acknowledges, strobes and read bytes.
module dpot_cmd_slave_tb;

    localparam int H = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [7:0] rd_val = 8'h00;

    logic       sda_drive_low;
    logic       cmd_valid;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg;
    logic [1:0] cmd_pot;
    logic [7:0] cmd_data;
    logic       step_valid;
    logic       step_up;

    wire sda_line = m_sda & ~sda_drive_low;

    dpot_cmd_slave u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_line),
        .strap_addr    (strap),
        .rd_data       (rd_val),
        .sda_drive_low (sda_drive_low),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_reg       (cmd_reg),
        .cmd_pot       (cmd_pot),
        .cmd_data      (cmd_data),
        .step_valid    (step_valid),
        .step_up       (step_up)
    );

    int checks = 0;
    int errs   = 0;

    int          cmd_cnt  = 0;
    int          step_cnt = 0;
    int          up_cnt   = 0;
    logic [3:0]  last_op  = '0;
    logic [1:0]  last_reg = '0;
    logic [7:0]  last_data = '0;
    logic [31:0] step_hist = '0;

    // Strobe monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                cmd_cnt++;
                last_op   = cmd_op;
                last_reg  = cmd_reg;
                last_data = cmd_data;
            end
            if (step_valid) begin
                step_cnt++;
                step_hist = {step_hist[30:0], step_up};
                if (step_up) up_cnt++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_of(input logic [2:0] pins);
        return {4'b0101, pins, 1'b0};
    endfunction

    function automatic logic exp_instr_ack(input logic [7:0] ib);
        logic listed;
        listed = (ib[7:4] == 4'b1001) || (ib[7:4] == 4'b1010) ||
                 (ib[7:4] == 4'b1011) || (ib[7:4] == 4'b1100) ||
                 (ib[7:4] == 4'b1101) || (ib[7:4] == 4'b1110) ||
                 (ib[7:4] == 4'b0010);
        return listed && (ib[1:0] == 2'b00);
    endfunction

    function automatic logic is_xfer(input logic [3:0] op);
        return (op == 4'b1101) || (op == 4'b1110);
    endfunction

    function automatic logic is_read(input logic [3:0] op);
        return (op == 4'b1001) || (op == 4'b1011);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        wait_clk(4); m_sda = 1'b1;
        wait_clk(H); m_scl = 1'b1;
        wait_clk(H); m_sda = 1'b0;
        wait_clk(H); m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        wait_clk(4); m_sda = 1'b0;
        wait_clk(H); m_scl = 1'b1;
        wait_clk(H); m_sda = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_bit(input logic b);
        wait_clk(4); m_sda = b;
        wait_clk(H - 4); m_scl = 1'b1;
        wait_clk(H); m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wait_clk(4); m_sda = 1'b1;
        wait_clk(H - 4); m_scl = 1'b1;
        wait_clk(H / 2); ack = ~sda_line;
        wait_clk(H / 2); m_scl = 1'b0;
    endtask

    task automatic recv8(output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wait_clk(4); m_sda = 1'b1;
            wait_clk(H - 4); m_scl = 1'b1;
            wait_clk(H / 2); d = {d[6:0], sda_line};
            wait_clk(H / 2); m_scl = 1'b0;
        end
    endtask

    task automatic frame_head(input logic [7:0] ib, output logic a1, output logic a2);
        i2c_start();
        send_byte(addr_of(strap), a1);
        send_byte(ib, a2);
    endtask

    logic        a1, a2, a3;
    logic [3:0]  op;
    logic [1:0]  rg;
    logic [7:0]  dv, ib, d, v2;
    logic [31:0] exp_hist;
    int          c0, s0, u0, n_up;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed));
        wait_clk(6);
        chk("R9 drive under reset", sda_drive_low, 0);
        chk("R9 cmd under reset", cmd_valid, 0);
        chk("R9 step under reset", step_valid, 0);
        rst_n = 1'b1;
        wait_clk(6);

        // R4: writes with random register, data and opcode
        for (int k = 0; k < 8; k++) begin
            op = ($urandom % 2) ? 4'b1010 : 4'b1100;
            rg = 2'($urandom);
            dv = 8'($urandom);
            c0 = cmd_cnt;
            frame_head({op, rg, 2'b00}, a1, a2);
            send_byte(dv, a3);
            i2c_stop();
            chk("R2 address ack", a1, 1);
            chk("R3 instr ack", a2, 1);
            chk("R4 data ack", a3, 1);
            chk("R4 one strobe", cmd_cnt - c0, 1);
            chk("R4 opcode", last_op, op);
            chk("R4 register", last_reg, rg);
            chk("R4 data byte", last_data, dv);
            chk("R1 released after stop", sda_drive_low, 0);
        end

        // R2: wrong strap, wrong identity, set final bit
        for (int k = 0; k < 3; k++) begin
            case (k)
                0: ib = {4'b0101, ~strap, 1'b0};
                1: ib = {4'b0110, strap, 1'b0};
                default: ib = {4'b0101, strap, 1'b1};
            endcase
            c0 = cmd_cnt;
            i2c_start();
            send_byte(ib, a1);
            send_byte(8'hA0, a2);
            send_byte(8'h3C, a3);
            i2c_stop();
            chk("R2 mismatched address not acked", a1, 0);
            chk("R2 silent until start", a2 | a3, 0);
            chk("R2 no strobe", cmd_cnt - c0, 0);
        end

        // R3: bad pot select followed by data
        c0 = cmd_cnt;
        frame_head({4'b1010, 2'b01, 2'b01}, a1, a2);
        send_byte(8'h55, a3);
        i2c_stop();
        chk("R3 bad pot not acked", a2, 0);
        chk("R3 data after bad pot ignored", a3, 0);
        chk("R3 no register change", cmd_cnt - c0, 0);

        // R3 and R5: random instruction bytes plus directed transfers
        for (int k = 0; k < 24; k++) begin
            ib = 8'($urandom);
            if (k == 0) ib = 8'b1101_10_00;
            if (k == 1) ib = 8'b1110_01_00;
            if (k == 2) ib = 8'b0000_00_00;
            if (k == 3) ib = 8'b1110_00_10;
            c0 = cmd_cnt;
            frame_head(ib, a1, a2);
            if (a2 && is_read(ib[7:4])) begin
                recv8(d);
                send_bit(1'b1);
            end
            i2c_stop();
            chk("R3 instr ack decision", a2, exp_instr_ack(ib));
            chk("R5 transfer strobe", cmd_cnt - c0,
                (exp_instr_ack(ib) && is_xfer(ib[7:4])) ? 1 : 0);
            if (exp_instr_ack(ib) && is_xfer(ib[7:4])) begin
                chk("R5 transfer opcode", last_op, ib[7:4]);
                chk("R5 transfer register", last_reg, ib[3:2]);
            end
        end

        // R6: read, repeat on ACK with a new byte, stop on NACK
        for (int k = 0; k < 3; k++) begin
            op = (k == 1) ? 4'b1011 : 4'b1001;
            rd_val = 8'($urandom);
            if (k == 2) rd_val = 8'h00;
            v2 = 8'($urandom);
            c0 = cmd_cnt;
            frame_head({op, 2'(k), 2'b00}, a1, a2);
            recv8(d);
            chk("R6 first read byte", d, rd_val);
            rd_val = v2;
            send_bit(1'b0);
            recv8(d);
            chk("R6 repeated byte after ack", d, v2);
            send_bit(1'b1);
            recv8(d);
            chk("R6 silent after nack", d, 8'hFF);
            i2c_stop();
            chk("R6 no write strobe on read", cmd_cnt - c0, 0);
        end

        // R7: step mode with a random direction pattern, ended by STOP
        for (int k = 0; k < 2; k++) begin
            s0 = step_cnt;
            u0 = up_cnt;
            c0 = cmd_cnt;
            exp_hist = '0;
            n_up = 0;
            frame_head(8'b0010_00_00, a1, a2);
            chk("R3 step instr ack", a2, 1);
            for (int i = 0; i < 12; i++) begin
                a3 = 1'($urandom);
                if (k == 1 && i < 2) a3 = 1'b1;
                exp_hist = {exp_hist[30:0], a3};
                if (a3) n_up++;
                send_bit(a3);
            end
            i2c_stop();
            chk("R7 step count", step_cnt - s0, 12);
            chk("R7 up count", up_cnt - u0, n_up);
            chk("R7 direction order", step_hist[11:0], exp_hist[11:0]);
            chk("R8 no command in step mode", cmd_cnt - c0, 0);
        end
        s0 = step_cnt;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        wait_clk(8);
        chk("R7 no steps after stop", step_cnt - s0, 0);

        // R1: repeated START in the middle of an address byte
        c0 = cmd_cnt;
        i2c_start();
        for (int i = 7; i >= 3; i--) send_bit(addr_of(strap)[i]);
        i2c_start();
        send_byte(addr_of(strap), a1);
        send_byte({4'b1100, 2'b11, 2'b00}, a2);
        send_byte(8'hA5, a3);
        i2c_stop();
        chk("R1 address after restart", a1, 1);
        chk("R1 write after restart", cmd_cnt - c0, 1);
        chk("R1 data after restart", last_data, 8'hA5);
        chk("R1 line released", sda_drive_low, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule